// File: doc/BRIEF.md
# Interval Timer Host Register Block

This block sits between a byte-wide host bus and three down-counting timer channels. A small address space reaches it. Each of three offsets is the data port of one channel, and a fourth offset takes control words. A control word either reprograms a channel or freezes a snapshot of that channel's count. Reprogramming sets the channel's counting mode, its decimal or binary flag and its byte access pattern.

On the write side the block builds each 16-bit reload value from one or two byte writes. It hands the finished value to the channel with a one-cycle load pulse. On the read side it returns either the live count coming back from the channel or a frozen snapshot, one byte per read, in the order the channel's access pattern sets. The counting and waveform logic inside the channels lie outside this block.

Top module: `tmr_host_regs`

## Requirements
- R1: Offsets 0, 1 and 2 are the data ports of channels 0, 1 and 2. Offset 3 accepts control words, and a read of offset 3 returns 0x00.
- R2: Control word fields are: bits 7:6 the channel, bits 5:4 the access pattern, bits 3:1 the mode and bit 0 the decimal flag. A control word with a nonzero access pattern stores the mode and flag unchanged on `ch_mode` and `ch_bcd` from the next cycle. For example, 0x34 gives channel 0 mode 2, binary, low-then-high access.
- R3: With access pattern 1 (low byte only), each data write loads `{8'h00, byte}` into the channel's `ld_value`. `ld_strobe` is high for exactly the one cycle after the write.
- R4: With access pattern 2 (high byte only), each data write loads `{byte, 8'h00}` and pulses `ld_strobe` in the same way.
- R5: With access pattern 3, the first data write is the low byte and causes no strobe. The second is the high byte; it loads `{high, low}` and pulses `ld_strobe`.
- R6: A control word whose channel field is 3 changes no channel's mode, flag, access pattern or latch.
- R7: A control word that programs a channel restarts both its write and read byte sequences at the low byte.
- R8: When no snapshot is held, reads return bytes of the live count `ch_count`: the low byte for pattern 1, the high byte for pattern 2, and alternately low then high for pattern 3.
- R9: A control word with access pattern 0 captures the channel's live count at that clock edge. Reads then return bytes of the captured value, in the R8 byte order, while the live count goes on changing.
- R10: A snapshot is held until the read that completes the byte sequence: one read for patterns 1 and 2, the high-byte read for pattern 3. A second capture command issued while a snapshot is held has no effect.
- R11: After the snapshot is released, reads return the live count again.
- R12: After reset, every channel has mode 0, binary, access pattern 3, `ld_value` of 0 and no strobe, and both byte sequences start at the low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write this cycle |
| rd_en | input | 1 | Host read this cycle (ignored when wr_en is high) |
| addr | input | 2 | Register offset |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte, valid combinationally while rd_en is high |
| ch_count | input | 48 | Live 16-bit count of each channel, channel 0 in the low bits |
| ld_value | output | 48 | Assembled reload value of each channel |
| ld_strobe | output | 3 | One-cycle load pulse per channel |
| ch_mode | output | 9 | 3-bit mode per channel |
| ch_bcd | output | 3 | Decimal counting flag per channel |

## Verification
The bench applies all 256 control bytes in turn and compares every channel's mode and flag after each one. This separates correct field slicing and channel steering from stray updates, including those caused by capture commands and by channel-select 3. Reload assembly is tried on every channel under all three access patterns with sixteen distinct byte pairs. These pairs separate low and high byte placement, and they show whether the strobe comes after the first byte or only the second. Reads are tried with changing live counts, with sequences cut short by a new control word, and with snapshots that are re-requested while still held. This tells frozen values from live ones and an early release from a late one.

// File: rtl/tmr_host_pkg.sv
package tmr_host_pkg;

  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int MODE_W = 3;

  typedef enum logic [1:0] {
    ACC_SNAP = 2'd0,
    ACC_LO   = 2'd1,
    ACC_HI   = 2'd2,
    ACC_LOHI = 2'd3
  } acc_e;

  typedef struct packed {
    logic [1:0]        sel;
    acc_e              acc;
    logic [MODE_W-1:0] mode;
    logic              bcd;
  } ctl_word_t;

  // Byte presented to the host for a given access pattern and sequence step.
  function automatic logic [BYTE_W-1:0] pick_byte(input logic [CNT_W-1:0] v,
                                                  input acc_e a, input logic step);
    logic take_hi;
    take_hi = (a == ACC_HI) || ((a == ACC_LOHI) && step);
    return take_hi ? v[CNT_W-1:BYTE_W] : v[BYTE_W-1:0];
  endfunction

  // Reload value formed by the byte that completes a write sequence.
  function automatic logic [CNT_W-1:0] join_load(input acc_e a,
                                                 input logic [BYTE_W-1:0] staged,
                                                 input logic [BYTE_W-1:0] b);
    case (a)
      ACC_LO:  return {{BYTE_W{1'b0}}, b};
      ACC_HI:  return {b, {BYTE_W{1'b0}}};
      default: return {b, staged};
    endcase
  endfunction

  // True when this access finishes the byte sequence.
  function automatic logic seq_done(input acc_e a, input logic step);
    return (a != ACC_LOHI) || step;
  endfunction

endpackage

// File: rtl/tmr_addr_dec.sv
module tmr_addr_dec
  import tmr_host_pkg::*;
#(
  parameter int NUM_CH = 3,
  localparam int ADDR_W = $clog2(NUM_CH + 1)
) (
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [NUM_CH-1:0] data_wr,
  output logic [NUM_CH-1:0] data_rd,
  output logic [NUM_CH-1:0] cw_prog,
  output logic [NUM_CH-1:0] snap_req,
  output acc_e              cw_acc,
  output logic [MODE_W-1:0] cw_mode,
  output logic              cw_bcd
);
  localparam logic [ADDR_W-1:0] CTRL_OFS = ADDR_W'(NUM_CH);

  ctl_word_t cw;
  logic      ctrl_wr;

  assign cw      = ctl_word_t'(wdata);
  assign ctrl_wr = wr_en && (addr == CTRL_OFS);
  assign cw_acc  = cw.acc;
  assign cw_mode = cw.mode;
  assign cw_bcd  = cw.bcd;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
    logic ofs_hit, sel_hit;
    assign ofs_hit     = (addr == ADDR_W'(i));
    assign sel_hit     = (cw.sel == 2'(i));
    assign data_wr[i]  = wr_en && ofs_hit;
    assign data_rd[i]  = rd_en && !wr_en && ofs_hit;
    assign cw_prog[i]  = ctrl_wr && sel_hit && (cw.acc != ACC_SNAP);
    assign snap_req[i] = ctrl_wr && sel_hit && (cw.acc == ACC_SNAP);
  end

endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
  import tmr_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cw_prog,
  input  logic              snap_req,
  input  logic              data_wr,
  input  logic              data_rd,
  input  acc_e              cw_acc,
  input  logic [MODE_W-1:0] cw_mode,
  input  logic              cw_bcd,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [CNT_W-1:0]  live,
  output logic [BYTE_W-1:0] rd_byte,
  output logic [CNT_W-1:0]  ld_value,
  output logic              ld_strobe,
  output logic [MODE_W-1:0] mode,
  output logic              bcd,
  output logic              held,
  output logic [CNT_W-1:0]  snap_val,
  output logic              wr_step,
  output logic              rd_step
);
  acc_e              acc;
  logic [BYTE_W-1:0] lo_stage;
  logic              rd_final;

  assign rd_final = data_rd && seq_done(acc, rd_step);
  assign rd_byte  = pick_byte(held ? snap_val : live, acc, rd_step);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc       <= ACC_LOHI;
      mode      <= '0;
      bcd       <= 1'b0;
      wr_step   <= 1'b0;
      rd_step   <= 1'b0;
      lo_stage  <= '0;
      ld_value  <= '0;
      ld_strobe <= 1'b0;
      held      <= 1'b0;
      snap_val  <= '0;
    end else begin
      ld_strobe <= 1'b0;
      if (cw_prog) begin
        acc     <= cw_acc;
        mode    <= cw_mode;
        bcd     <= cw_bcd;
        wr_step <= 1'b0;
        rd_step <= 1'b0;
        held    <= 1'b0;
      end else begin
        if (snap_req && !held) begin
          held     <= 1'b1;
          snap_val <= live;
        end else if (rd_final) begin
          held <= 1'b0;
        end
        if (data_wr) begin
          if (!seq_done(acc, wr_step)) begin
            lo_stage <= wdata;
            wr_step  <= 1'b1;
          end else begin
            ld_value  <= join_load(acc, lo_stage, wdata);
            ld_strobe <= 1'b1;
            wr_step   <= 1'b0;
          end
        end
        if (data_rd && (acc == ACC_LOHI)) rd_step <= !rd_step;
      end
    end
  end

endmodule

// File: rtl/tmr_host_regs.sv
module tmr_host_regs
  import tmr_host_pkg::*;
#(
  parameter int NUM_CH = 3,
  localparam int ADDR_W = $clog2(NUM_CH + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic                     rd_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [BYTE_W-1:0]        wdata,
  output logic [BYTE_W-1:0]        rdata,
  input  logic [NUM_CH*CNT_W-1:0]  ch_count,
  output logic [NUM_CH*CNT_W-1:0]  ld_value,
  output logic [NUM_CH-1:0]        ld_strobe,
  output logic [NUM_CH*MODE_W-1:0] ch_mode,
  output logic [NUM_CH-1:0]        ch_bcd
);
  logic [NUM_CH-1:0]       data_wr, data_rd, cw_prog, snap_req;
  acc_e                    cw_acc;
  logic [MODE_W-1:0]       cw_mode;
  logic                    cw_bcd;
  logic [BYTE_W-1:0]       ch_rd [NUM_CH];

  // Internal events brought out for the checker
  logic [NUM_CH-1:0]       ch_held;
  logic [NUM_CH*CNT_W-1:0] ch_snap;
  logic [NUM_CH-1:0]       ch_wr_step, ch_rd_step;

  tmr_addr_dec #(.NUM_CH(NUM_CH)) u_dec (
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .wdata    (wdata),
    .data_wr  (data_wr),
    .data_rd  (data_rd),
    .cw_prog  (cw_prog),
    .snap_req (snap_req),
    .cw_acc   (cw_acc),
    .cw_mode  (cw_mode),
    .cw_bcd   (cw_bcd)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    tmr_chan_regs u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .cw_prog   (cw_prog[i]),
      .snap_req  (snap_req[i]),
      .data_wr   (data_wr[i]),
      .data_rd   (data_rd[i]),
      .cw_acc    (cw_acc),
      .cw_mode   (cw_mode),
      .cw_bcd    (cw_bcd),
      .wdata     (wdata),
      .live      (ch_count[i*CNT_W +: CNT_W]),
      .rd_byte   (ch_rd[i]),
      .ld_value  (ld_value[i*CNT_W +: CNT_W]),
      .ld_strobe (ld_strobe[i]),
      .mode      (ch_mode[i*MODE_W +: MODE_W]),
      .bcd       (ch_bcd[i]),
      .held      (ch_held[i]),
      .snap_val  (ch_snap[i*CNT_W +: CNT_W]),
      .wr_step   (ch_wr_step[i]),
      .rd_step   (ch_rd_step[i])
    );
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (data_rd[i]) rdata = ch_rd[i];
    end
  end

endmodule

// File: rtl/tmr_host_regs_chk.sv
module tmr_host_regs_chk #(
  parameter int NUM_CH = 3,
  localparam int ADDR_W = $clog2(NUM_CH + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic                 rd_en,
  input logic [ADDR_W-1:0]    addr,
  input logic [7:0]           wdata,
  input logic [7:0]           rdata,
  input logic [NUM_CH-1:0]    ld_strobe,
  input logic [NUM_CH*3-1:0]  ch_mode,
  input logic [NUM_CH-1:0]    ch_bcd,
  input logic [NUM_CH-1:0]    ch_held,
  input logic [NUM_CH*16-1:0] ch_snap,
  input logic [NUM_CH-1:0]    ch_wr_step,
  input logic [NUM_CH-1:0]    ch_rd_step
);
  localparam logic [ADDR_W-1:0] CTRL_OFS = ADDR_W'(NUM_CH);

  logic ctrl_wr;
  assign ctrl_wr = wr_en && (addr == CTRL_OFS);

  a_r1_ctrl_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && addr == CTRL_OFS) |-> (rdata == 8'h00));

  a_r6_sel3_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctrl_wr && wdata[7:6] == 2'd3) |-> ($stable(ch_mode) && $stable(ch_bcd)));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    a_r3_strobe_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
      ld_strobe[i] |-> $past(wr_en && addr == ADDR_W'(i)));

    a_r2_mode_captured: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ctrl_wr && wdata[7:6] == 2'(i) && wdata[5:4] != 2'd0)
      |-> (ch_mode[i*3 +: 3] == $past(wdata[3:1]) && ch_bcd[i] == $past(wdata[0])));

    a_r7_cw_restarts_bytes: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ctrl_wr && wdata[7:6] == 2'(i) && wdata[5:4] != 2'd0)
      |-> (!ch_wr_step[i] && !ch_rd_step[i] && !ch_held[i]));

    a_r10_snapshot_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_held[i] && $past(ch_held[i])) |-> $stable(ch_snap[i*16 +: 16]));
  end

endmodule

bind tmr_host_regs tmr_host_regs_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .addr       (addr),
  .wdata      (wdata),
  .rdata      (rdata),
  .ld_strobe  (ld_strobe),
  .ch_mode    (ch_mode),
  .ch_bcd     (ch_bcd),
  .ch_held    (ch_held),
  .ch_snap    (ch_snap),
  .ch_wr_step (ch_wr_step),
  .ch_rd_step (ch_rd_step)
);

// File: tb/test_tmr_host_regs.sv
module test_tmr_host_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [47:0] ch_count = '0;
  logic [47:0] ld_value;
  logic [2:0]  ld_strobe;
  logic [8:0]  ch_mode;
  logic [2:0]  ch_bcd;

  int vectors = 0;
  int miscompares = 0;

  always #4 clk = ~clk;

  tmr_host_regs i_tmr_host_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ch_count(ch_count), .ld_value(ld_value),
    .ld_strobe(ld_strobe), .ch_mode(ch_mode), .ch_bcd(ch_bcd)
  );

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #2;
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(posedge clk); #2;
    rd_en = 1'b0;
  endtask

  task automatic idle();
    @(posedge clk); #2;
  endtask

  function automatic logic [7:0] cwb(input int sel, input int acc, input int mode);
    return 8'((sel << 6) | (acc << 4) | (mode << 1));
  endfunction

  task automatic set_live(input int ch, input logic [15:0] v);
    ch_count[ch*16 +: 16] = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    int exp_mode [3];
    int exp_bcd [3];
    logic [7:0] b, b2;
    logic [15:0] v;

    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R12 reset state
    for (int i = 0; i < 3; i++) begin
      check("R12 mode", ch_mode[i*3 +: 3], 0);
      check("R12 bcd", ch_bcd[i], 0);
      check("R12 ld_value", ld_value[i*16 +: 16], 0);
      check("R12 strobe", ld_strobe[i], 0);
      exp_mode[i] = 0; exp_bcd[i] = 0;
    end
    set_live(0, 16'hA51C);
    bus_rd(2'd0, b);  check("R12 first read low", b, 8'h1C);
    bus_rd(2'd0, b);  check("R8 second read high", b, 8'hA5);

    // R1 control offset reads as zero
    bus_rd(2'd3, b);  check("R1 ctrl read", b, 0);

    // R2 example word 0x34
    bus_wr(2'd3, 8'h34);
    check("R2 0x34 mode", ch_mode[2:0], 2);
    check("R2 0x34 bcd", ch_bcd[0], 0);
    exp_mode[0] = 2;

    // R2 / R6 sweep over every control byte
    for (int w = 0; w < 256; w++) begin
      bus_wr(2'd3, 8'(w));
      if ((w >> 6) != 3 && ((w >> 4) & 3) != 0) begin
        exp_mode[w >> 6] = (w >> 1) & 7;
        exp_bcd[w >> 6]  = w & 1;
      end
      for (int i = 0; i < 3; i++) begin
        check((w >> 6) == 3 ? "R6 mode" : "R2 mode", ch_mode[i*3 +: 3], exp_mode[i]);
        check((w >> 6) == 3 ? "R6 bcd" : "R2 bcd", ch_bcd[i], exp_bcd[i]);
      end
    end

    // R3 / R4 / R5 reload assembly on every channel and pattern
    for (int ch = 0; ch < 3; ch++) begin
      for (int acc = 1; acc <= 3; acc++) begin
        bus_wr(2'd3, cwb(ch, acc, 2));
        for (int k = 0; k < 16; k++) begin
          logic [7:0] lo, hi;
          lo = 8'((k * 37 + 5) & 255);
          hi = 8'((k * 91 + 3) & 255);
          if (acc == 3) begin
            bus_wr(2'(ch), lo);
            check("R5 no strobe after low", ld_strobe[ch], 0);
            bus_wr(2'(ch), hi);
            check("R5 strobe", ld_strobe[ch], 1);
            check("R5 value", ld_value[ch*16 +: 16], {hi, lo});
          end else begin
            bus_wr(2'(ch), acc == 1 ? lo : hi);
            check(acc == 1 ? "R3 strobe" : "R4 strobe", ld_strobe[ch], 1);
            check(acc == 1 ? "R3 value" : "R4 value", ld_value[ch*16 +: 16],
                  acc == 1 ? {8'h00, lo} : {hi, 8'h00});
          end
          idle();
          check("R3 strobe one cycle", ld_strobe, 0);
        end
      end
    end

    // R7 control word restarts both byte sequences
    bus_wr(2'd3, cwb(1, 3, 0));
    bus_wr(2'd1, 8'h11);
    bus_wr(2'd3, cwb(1, 3, 0));
    bus_wr(2'd1, 8'h22);
    check("R7 no strobe on restarted low", ld_strobe[1], 0);
    bus_wr(2'd1, 8'h33);
    check("R7 value", ld_value[31:16], 16'h3322);
    set_live(1, 16'hBEEF);
    bus_rd(2'd1, b);
    bus_wr(2'd3, cwb(1, 3, 0));
    bus_rd(2'd1, b);  check("R7 read restarts low", b, 8'hEF);
    bus_wr(2'd3, cwb(1, 3, 0));

    // R8 live reads under each pattern
    for (int ch = 0; ch < 3; ch++) begin
      for (int acc = 1; acc <= 3; acc++) begin
        bus_wr(2'd3, cwb(ch, acc, 3));
        for (int k = 0; k < 8; k++) begin
          v = 16'((k * 16'h0F1D) ^ (ch << 12) ^ 16'h5A00);
          set_live(ch, v);
          bus_rd(2'(ch), b);
          bus_rd(2'(ch), b2);
          check("R8 first byte", b, acc == 2 ? v[15:8] : v[7:0]);
          check("R8 second byte", b2, acc == 1 ? v[7:0] : v[15:8]);
        end
      end
    end

    // R9 / R10 / R11 snapshot with low-then-high pattern
    for (int ch = 0; ch < 3; ch++) begin
      bus_wr(2'd3, cwb(ch, 3, 2));
      set_live(ch, 16'h1357);
      bus_wr(2'd3, cwb(ch, 0, 0));
      set_live(ch, 16'h2468);
      bus_rd(2'(ch), b);  check("R9 snapshot low", b, 8'h57);
      set_live(ch, 16'hFACE);
      bus_wr(2'd3, cwb(ch, 0, 0));
      bus_rd(2'(ch), b);  check("R10 second capture ignored", b, 8'h13);
      bus_rd(2'(ch), b);  check("R11 live low after release", b, 8'hCE);
      bus_rd(2'(ch), b);  check("R11 live high", b, 8'hFA);
    end

    // R10 snapshot with single-byte patterns releases after one read
    for (int acc = 1; acc <= 2; acc++) begin
      bus_wr(2'd3, cwb(2, acc, 0));
      set_live(2, 16'h7E81);
      bus_wr(2'd3, cwb(2, 0, 0));
      set_live(2, 16'h0C3D);
      bus_wr(2'd3, cwb(2, 0, 0));
      bus_rd(2'd2, b);  check("R10 single-byte snapshot", b, acc == 1 ? 8'h81 : 8'h7E);
      bus_rd(2'd2, b);  check("R11 single-byte live", b, acc == 1 ? 8'h3D : 8'h0C);
    end

    // R6 select 3 leaves a held snapshot and the access pattern alone
    bus_wr(2'd3, cwb(0, 3, 1));
    set_live(0, 16'h4242);
    bus_wr(2'd3, cwb(0, 0, 0));
    set_live(0, 16'h9999);
    bus_wr(2'd3, cwb(3, 1, 4));
    bus_rd(2'd0, b);  check("R6 snapshot kept low", b, 8'h42);
    bus_rd(2'd0, b);  check("R6 pattern kept high", b, 8'h42);
    check("R6 mode kept", ch_mode[2:0], 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule